// File: doc/BRIEF.md
# Quadrature Encoder Looping Compare Timer

This block is a 16-bit up/down counter driven by a two-phase (quadrature) encoder decoded at 1x resolution. Each full encoder cycle moves the count by one. The direction comes from the order of the two phases. The count loops between zero and a programmable limit in both directions. A second programmable value is compared with the count, and a matching count step raises an interrupt request. This happens when counting up and when counting down.

Software works the block through a word-wide register bus. It holds the block cleared with both the run bit and the release bit at zero. It then sets the release bit alone, so that the counter comes out of clear without counting. Finally it sets the run bit as well to start counting. The current count can be read at any time through a read-only register. The interrupt request has an enable bit, and a pending bit that software clears by writing 0 to it.

Top module: `quad_loop_timer`

## Requirements
- R1: After reset, every register reads 0x0000, the count is 0 and `irqOut` is low.
- R2: All writes are whole 16-bit words. Register addresses are: 0 = mode, 1 = loop limit, 2 = compare value, 3 = interrupt control, 4 = count (read only). Mode bit 15 is run, bit 14 is release, and bits 2:0 select the count source. The mode, limit and compare registers read back what was written. Reading the count any number of times leaves it unchanged.
- R3: With run = 1, release = 1 and source code 3'b101, each rising edge of phase A changes the count by one. The count goes up when phase B is low at that edge and down when phase B is high. A falling edge of phase A does not count, and phase B edges alone do not count. Mode bits 13:12 have no effect.
- R4: A count step up from a count equal to the loop limit gives 0.
- R5: A count step down from 0 reloads the count with the loop limit.
- R6: While release (mode bit 14) is 0, the count is held at 0 whatever the phase inputs do.
- R7: With release = 1 and run = 0, the count keeps its value and encoder edges do not count.
- R8: With any source code other than 3'b101, encoder edges do not count.
- R9: When a count step, up or down, lands on the compare value and interrupt enable (register 3 bit 0) is 1, the pending bit (register 3 bit 1) sets one clock after the count update.
- R10: A compare match while enable is 0 leaves pending at 0. Setting enable later does not set it.
- R11: Writing register 3 with bit 1 = 0 clears pending. Writing bit 1 = 1 never sets it.
- R12: `irqOut` equals the pending bit.
- R13: A write to the count address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Word write strobe |
| busAddr | input | 3 | Register address for writes and reads |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr` |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| irqOut | output | 1 | Compare interrupt request |

## Verification
The bench drives the count across the loop boundary both ways. A design that mixed up the reload value would read 0xFFFF or 1 instead of the limit after stepping down from zero, or the limit plus one after stepping up. It sets up compare matches reached while counting down, and a design that only compared when counting up would leave pending clear. It parks the count on the compare value, then enables the interrupt. A design that compared levels instead of steps would raise a spurious request there. It also sends phase B toggles alone, falling A edges, a foreign source code and a write to the count address. Each of these must leave the count read back unchanged.

// File: rtl/qlt_pkg.sv
package qlt_pkg;
  localparam int ADDR_W   = 3;
  localparam int RUN_BIT  = 15;
  localparam int LOAD_BIT = 14;
  localparam int SRC_W    = 3;
  localparam logic [SRC_W-1:0] SRC_QUAD = 3'b101;

  localparam logic [ADDR_W-1:0] REG_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_LIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CMP   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_IRQ   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_COUNT = 3'd4;

  localparam int IRQ_EN_BIT  = 0;
  localparam int IRQ_PND_BIT = 1;

  typedef struct packed {
    logic clear;
    logic stepUp;
    logic stepDown;
    logic irqEn;
    logic pendClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/qlt_phase_sync.sv
module qlt_phase_sync #(
  parameter int NUM_PH = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] phIn,
  output logic [NUM_PH-1:0] phSync
);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], phIn[p]};
    end
    assign phSync[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/qlt_ctrl.sv
module qlt_ctrl
  import qlt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              phaseA,
  input  logic              phaseB,
  output ctrlStrobes_t      stb,
  output logic [WIDTH-1:0]  modeVal,
  output logic [WIDTH-1:0]  limitVal,
  output logic [WIDTH-1:0]  cmpVal,
  output logic              irqEnVal
);
  localparam int NUM_PH = 2;

  logic [NUM_PH-1:0] phSync;
  logic              prevA;
  logic              riseA;
  logic              runOn;
  logic              loadOn;
  logic              srcOk;
  logic              countOk;

  qlt_phase_sync #(.NUM_PH(NUM_PH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .phIn  ({phaseB, phaseA}),
    .phSync(phSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevA <= 1'b0;
    else        prevA <= phSync[0];
  end

  assign riseA = phSync[0] & ~prevA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeVal  <= '0;
      limitVal <= '0;
      cmpVal   <= '0;
      irqEnVal <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        REG_MODE:  modeVal  <= wrData;
        REG_LIMIT: limitVal <= wrData;
        REG_CMP:   cmpVal   <= wrData;
        REG_IRQ:   irqEnVal <= wrData[IRQ_EN_BIT];
        default: ;
      endcase
    end
  end

  assign runOn   = modeVal[RUN_BIT];
  assign loadOn  = modeVal[LOAD_BIT];
  assign srcOk   = (modeVal[SRC_W-1:0] == SRC_QUAD);
  assign countOk = runOn & loadOn & srcOk & riseA;

  always_comb begin
    stb          = '0;
    stb.clear    = ~loadOn;
    stb.stepUp   = countOk & ~phSync[1];
    stb.stepDown = countOk &  phSync[1];
    stb.irqEn    = irqEnVal;
    stb.pendClr  = wrEn && (wrAddr == REG_IRQ) && !wrData[IRQ_PND_BIT];
  end
endmodule

// File: rtl/qlt_datapath.sv
module qlt_datapath
  import qlt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     stb,
  input  logic [WIDTH-1:0] limitVal,
  input  logic [WIDTH-1:0] cmpVal,
  output logic [WIDTH-1:0] cntVal,
  output logic             pending
);
  logic [WIDTH-1:0] cntNext;
  logic             stepQ;
  logic             hit;

  always_comb begin
    cntNext = cntVal;
    if (stb.stepUp)
      cntNext = (cntVal == limitVal) ? '0 : cntVal + 1'b1;
    else if (stb.stepDown)
      cntNext = (cntVal == '0) ? limitVal : cntVal - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntVal <= '0;
      stepQ  <= 1'b0;
    end else if (stb.clear) begin
      cntVal <= '0;
      stepQ  <= 1'b0;
    end else begin
      cntVal <= cntNext;
      stepQ  <= stb.stepUp | stb.stepDown;
    end
  end

  assign hit = stepQ && (cntVal == cmpVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pending <= 1'b0;
    else if (hit && stb.irqEn)  pending <= 1'b1;
    else if (stb.pendClr)       pending <= 1'b0;
  end
endmodule

// File: rtl/quad_loop_timer.sv
module quad_loop_timer
  import qlt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic              phaseA,
  input  logic              phaseB,
  output logic              irqOut
);
  ctrlStrobes_t     stb;
  logic [WIDTH-1:0] modeVal;
  logic [WIDTH-1:0] limitVal;
  logic [WIDTH-1:0] cmpVal;
  logic [WIDTH-1:0] cntVal;
  logic             irqEnVal;
  logic             pending;

  qlt_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (busWrEn),
    .wrAddr  (busAddr),
    .wrData  (busWrData),
    .phaseA  (phaseA),
    .phaseB  (phaseB),
    .stb     (stb),
    .modeVal (modeVal),
    .limitVal(limitVal),
    .cmpVal  (cmpVal),
    .irqEnVal(irqEnVal)
  );

  qlt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .limitVal(limitVal),
    .cmpVal  (cmpVal),
    .cntVal  (cntVal),
    .pending (pending)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      REG_MODE:  busRdData = modeVal;
      REG_LIMIT: busRdData = limitVal;
      REG_CMP:   busRdData = cmpVal;
      REG_IRQ: begin
        busRdData[IRQ_EN_BIT]  = irqEnVal;
        busRdData[IRQ_PND_BIT] = pending;
      end
      REG_COUNT: busRdData = cntVal;
      default:   busRdData = '0;
    endcase
  end

  assign irqOut = pending;
endmodule

// File: rtl/qlt_checker.sv
module qlt_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             runOn,
  input logic             loadOn,
  input logic             stepUp,
  input logic             stepDown,
  input logic             irqEn,
  input logic             pending,
  input logic [WIDTH-1:0] cntVal,
  input logic [WIDTH-1:0] limitVal
);
  // R6: release low holds the count at zero
  a_r6_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !loadOn |=> (cntVal == '0));

  // R7: released but not running keeps the count
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (loadOn && !runOn) |=> $stable(cntVal));

  // R4: step up at the limit wraps to zero
  a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (stepUp && loadOn && cntVal == limitVal) |=> (cntVal == '0));

  // R5: step down at zero reloads the limit
  a_r5_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (stepDown && loadOn && cntVal == '0) |=> (cntVal == $past(limitVal)));

  // R10: with enable off, pending cannot rise
  a_r10_no_pend_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqEn && !pending) |=> !pending);
endmodule

bind quad_loop_timer qlt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .runOn   (modeVal[15]),
  .loadOn  (modeVal[14]),
  .stepUp  (stb.stepUp),
  .stepDown(stb.stepDown),
  .irqEn   (stb.irqEn),
  .pending (pending),
  .cntVal  (cntVal),
  .limitVal(limitVal)
);

// File: tb/test_quad_loop_timer.sv
module test_quad_loop_timer;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             busWrEn = 1'b0;
  logic [2:0]       busAddr = '0;
  logic [WIDTH-1:0] busWrData = '0;
  logic [WIDTH-1:0] busRdData;
  logic             phaseA = 1'b0;
  logic             phaseB = 1'b0;
  logic             irqOut;

  always #2.5 clk = ~clk;

  quad_loop_timer #(.WIDTH(WIDTH)) i_quad_loop_timer (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .phaseA(phaseA),
    .phaseB(phaseB), .irqOut(irqOut)
  );

  typedef struct {
    bit          isIrq;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;

  // Monitor: compares one queued item per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = expQ.pop_front();
      act = it.isIrq ? {15'd0, irqOut} : busRdData;
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic expRd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    busAddr = a;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic expIrq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.isIrq = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic encStep(input logic down);
    @(posedge clk); #1;
    phaseB = down;
    repeat (3) @(posedge clk);
    #1 phaseA = 1'b1;
    repeat (5) @(posedge clk);
    #1 phaseA = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expRd(3'd0, 16'h0000, "R1 mode");
    expRd(3'd1, 16'h0000, "R1 limit");
    expRd(3'd2, 16'h0000, "R1 cmp");
    expRd(3'd3, 16'h0000, "R1 irqctl");
    expRd(3'd4, 16'h0000, "R1 count");
    expIrq(1'b0, "R1 irqOut");

    // R2 register setup and readback
    wr(3'd1, 16'h0005);
    wr(3'd2, 16'h0003);
    wr(3'd0, 16'h0005);
    expRd(3'd1, 16'h0005, "R2 limit readback");
    expRd(3'd2, 16'h0003, "R2 cmp readback");

    // R6 held clear while release is 0
    encStep(1'b0); encStep(1'b0);
    expRd(3'd4, 16'h0000, "R6 held clear");

    // R7 released, not running
    wr(3'd0, 16'h4005);
    encStep(1'b0);
    expRd(3'd4, 16'h0000, "R7 no count while run low");

    // R3 counting up
    wr(3'd0, 16'hC005);
    wr(3'd3, 16'h0001);
    encStep(1'b0); encStep(1'b0);
    expRd(3'd4, 16'h0002, "R3 up count");
    expRd(3'd4, 16'h0002, "R2 reread no side effect");
    expIrq(1'b0, "R9 no match yet");

    // R9 up match
    encStep(1'b0);
    expRd(3'd4, 16'h0003, "R3 up to cmp");
    expIrq(1'b1, "R12 irqOut on up match");
    expRd(3'd3, 16'h0003, "R9 pending set up");

    // R11 clear
    wr(3'd3, 16'h0001);
    expRd(3'd3, 16'h0001, "R11 pending cleared");
    expIrq(1'b0, "R12 irqOut low after clear");

    // R4 wrap up
    encStep(1'b0); encStep(1'b0);
    expRd(3'd4, 16'h0005, "R4 at limit");
    encStep(1'b0);
    expRd(3'd4, 16'h0000, "R4 wrap to zero");

    // R5 reload down
    encStep(1'b1);
    expRd(3'd4, 16'h0005, "R5 reload limit");
    encStep(1'b1); encStep(1'b1);
    expRd(3'd4, 16'h0003, "R3 down count");
    expRd(3'd3, 16'h0003, "R9 pending set down");
    wr(3'd3, 16'h0001);

    // R3 phase B alone and A falling do not count
    @(posedge clk); #1 phaseB = ~phaseB;
    repeat (6) @(posedge clk);
    #1 phaseB = ~phaseB;
    repeat (6) @(posedge clk);
    expRd(3'd4, 16'h0003, "R3 B edges ignored");

    // R11 writing 1 does not set pending
    wr(3'd3, 16'h0003);
    expRd(3'd3, 16'h0001, "R11 write one no set");

    // R3 direction select bits ignored
    wr(3'd0, 16'hF005);
    expRd(3'd0, 16'hF005, "R2 mode readback");
    encStep(1'b0);
    expRd(3'd4, 16'h0004, "R3 mode bits 13:12 ignored");

    // R8 other source
    wr(3'd0, 16'hC004);
    encStep(1'b0);
    expRd(3'd4, 16'h0004, "R8 foreign source no count");
    wr(3'd0, 16'hC005);

    // R10 disabled match, then late enable
    wr(3'd3, 16'h0000);
    encStep(1'b1);
    expRd(3'd4, 16'h0003, "R10 count at cmp");
    expRd(3'd3, 16'h0000, "R10 no pending disabled");
    wr(3'd3, 16'h0001);
    repeat (3) @(posedge clk);
    expRd(3'd3, 16'h0001, "R10 late enable no pending");
    expIrq(1'b0, "R10 irqOut low");

    // R13 count not writable
    wr(3'd4, 16'h1234);
    expRd(3'd4, 16'h0003, "R13 count write ignored");

    // R6 clear from running
    wr(3'd0, 16'h0005);
    expRd(3'd4, 16'h0000, "R6 cleared on release low");

    repeat (3) @(posedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule